// File: doc/BRIEF.md
# Interrupt Descriptor Ring Writer

This block posts transmit and receive completion events into two circular rings kept in host memory. There is one ring per direction, and each ring has 128 slots. A slot is two 16-bit words. The first word carries the lower part of a 24-bit context-table address. The second word carries an ownership flag, a 7-bit descriptor index and the upper address byte.

When an event arrives, the block reads the ownership word of the slot it intends to fill. If the host has released that slot, the block writes the address word and then the ownership word with the flag set. It then pulses the interrupt for that direction. If the host still owns the slot, the block writes nothing and emits a miss strobe. A receive-side miss also tells the frame path to discard its frame. Either direction's event can carry a per-descriptor suppress bit. A suppressed event is consumed with no memory traffic and no interrupt.

Both event inputs share one word-wide memory port. They are served one at a time, and receive wins when both are pending.

Top module: `intr_ring_writer`

## Requirements
- R1: A posted entry places context bits 15:0 in the word at slot offset 0. It places {1'b1, descriptor[6:0], context[23:16]} in the word at slot offset 2, so bit 15 is the ownership flag, bits 14:8 are the descriptor and bits 7:0 are context bits 23:16.
- R2: The slot byte address is the ring base plus 4 times that ring's write index. Both indices are 0 after reset.
- R3: A ring's write index grows by one after each successful post and wraps from 127 to 0. The other ring's index is unaffected.
- R4: Before any write, the block reads the offset-2 word of the target slot. On a post, the offset-0 word is written strictly before the offset-2 word.
- R5: A successful post gives a one-cycle pulse on the interrupt output of the event's direction.
- R6: If bit 15 of the read word is 1, nothing is written and the index is kept, so the same slot is retried next time. miss_stb pulses for one cycle with miss_code 7 and miss_parm 0 for transmit or 1 for receive. The direction's interrupt still pulses in the same cycle.
- R7: rx_drop pulses together with a receive miss and never on a transmit miss.
- R8: An event whose suppress bit is 1 is accepted but causes no memory access, no interrupt and no index change.
- R9: Each event input is held by valid/ready until accepted, and at most one is accepted per cycle. When both are valid, receive is accepted first. The two interrupt outputs never pulse together.
- R10: After reset no interrupt, miss, drop or memory request is active, and an idle block offers ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| tx_evt_valid | input | 1 | transmit event pending |
| tx_evt_ready | output | 1 | transmit event accepted this cycle when valid |
| tx_evt_ctx | input | 24 | transmit context-table address |
| tx_evt_desc | input | 7 | transmit descriptor index |
| tx_evt_noint | input | 1 | suppress this transmit event |
| rx_evt_valid | input | 1 | receive event pending |
| rx_evt_ready | output | 1 | receive event accepted this cycle when valid |
| rx_evt_ctx | input | 24 | receive context-table address |
| rx_evt_desc | input | 7 | receive descriptor index |
| rx_evt_noint | input | 1 | suppress this receive event |
| tx_ring_base | input | 24 | byte base of transmit ring, 4-byte aligned |
| rx_ring_base | input | 24 | byte base of receive ring, 4-byte aligned |
| mem_req | output | 1 | memory access this cycle |
| mem_we | output | 1 | access is a write |
| mem_addr | output | 24 | byte address of the 16-bit word |
| mem_wdata | output | 16 | write data |
| mem_rdata | input | 16 | read data, valid the cycle after a read request |
| tx_irq | output | 1 | transmit interrupt pulse |
| rx_irq | output | 1 | receive interrupt pulse |
| miss_stb | output | 1 | slot-still-owned report strobe |
| miss_code | output | 3 | report code, 7 while miss_stb |
| miss_parm | output | 1 | report parameter, 0 transmit, 1 receive |
| rx_drop | output | 1 | discard the receive frame |

## Verification
Several properties are checked on every cycle: the single-grant and receive-first handshake, the rule that the ownership word follows the address word two bytes higher, the read-before-write ordering, the code and direction carried by each miss strobe, and the one-step advance and hold of each index. Other behaviour can only be shown by the directed scenarios, because it depends on memory contents. These are the exact contents written to each slot, slot placement relative to the bases, a retry landing on the same slot after the host clears it, wrap-around at slot 127, and the complete silence that follows a suppressed event.

// File: rtl/irw_pkg.sv
package irw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WR_LO,
    ST_WR_HI
  } irw_state_e;

  localparam logic [2:0] MISS_CODE = 3'd7;
  localparam logic       DIR_TX    = 1'b0;
  localparam logic       DIR_RX    = 1'b1;
endpackage

// File: rtl/irw_arbiter.sv
module irw_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic tx_valid,
  input  logic rx_valid,
  output logic tx_ready,
  output logic rx_ready,
  output logic pick_rx
);
  assign pick_rx  = rx_valid;
  assign rx_ready = idle;
  assign tx_ready = idle & ~rx_valid;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    !(tx_valid && tx_ready && rx_valid && rx_ready)); // R9
  AST_RX_FIRST: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && rx_valid && idle) |-> (rx_ready && !tx_ready)); // R9
endmodule

// File: rtl/irw_ring_index.sv
module irw_ring_index #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= idx + 1'b1;
  end

  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    adv |=> idx == $past(idx) + 1'b1); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(idx)); // R6
endmodule

// File: rtl/irw_sequencer.sv
module irw_sequencer
  import irw_pkg::*;
#(
  parameter int CTX_W  = 24,
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic              idle,
  input  logic              acc_valid,
  input  logic              acc_dir,
  input  logic [CTX_W-1:0]  acc_ctx,
  input  logic [IDX_W-1:0]  acc_desc,
  input  logic              acc_noint,
  input  logic [ADDR_W-1:0] tx_base,
  input  logic [ADDR_W-1:0] rx_base,
  input  logic [IDX_W-1:0]  tx_idx,
  input  logic [IDX_W-1:0]  rx_idx,
  output logic [1:0]        adv,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              miss_stb,
  output logic [2:0]        miss_code,
  output logic              miss_parm,
  output logic              rx_drop
);
  localparam int PAD_W   = ADDR_W - IDX_W - 2;
  localparam int HI_W    = CTX_W - WORD_W;
  localparam int FLAG_B  = WORD_W - 1;

  irw_state_e        state;
  logic              cur_dir;
  logic [CTX_W-1:0]  cur_ctx;
  logic [IDX_W-1:0]  cur_desc;
  logic [ADDR_W-1:0] slot;
  logic [ADDR_W-1:0] next_slot;
  logic [IDX_W-1:0]  sel_idx;
  logic              slot_owned;
  logic [WORD_W-2:0] unused_rdata_bits;

  assign unused_rdata_bits = mem_rdata[WORD_W-2:0];
  assign slot_owned = mem_rdata[FLAG_B];
  assign sel_idx    = acc_dir ? rx_idx : tx_idx;
  assign next_slot  = (acc_dir ? rx_base : tx_base) + {{PAD_W{1'b0}}, sel_idx, 2'b00};
  assign idle       = (state == ST_IDLE);

  always_comb begin
    mem_req   = (state == ST_READ) || (state == ST_WR_LO) || (state == ST_WR_HI);
    mem_we    = (state == ST_WR_LO) || (state == ST_WR_HI);
    mem_addr  = (state == ST_WR_LO) ? slot : slot + ADDR_W'(2);
    mem_wdata = (state == ST_WR_LO) ? cur_ctx[WORD_W-1:0]
                                    : {1'b1, cur_desc, cur_ctx[CTX_W-1 -: HI_W]};
    adv       = 2'b00;
    if (state == ST_WR_HI) adv[cur_dir] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_dir   <= DIR_TX;
      cur_ctx   <= '0;
      cur_desc  <= '0;
      slot      <= '0;
      tx_irq    <= 1'b0;
      rx_irq    <= 1'b0;
      miss_stb  <= 1'b0;
      miss_code <= 3'd0;
      miss_parm <= 1'b0;
      rx_drop   <= 1'b0;
    end else begin
      tx_irq    <= 1'b0;
      rx_irq    <= 1'b0;
      miss_stb  <= 1'b0;
      miss_code <= 3'd0;
      miss_parm <= 1'b0;
      rx_drop   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (acc_valid && !acc_noint) begin
            cur_dir  <= acc_dir;
            cur_ctx  <= acc_ctx;
            cur_desc <= acc_desc;
            slot     <= next_slot;
            state    <= ST_READ;
          end
        end
        ST_READ:  state <= ST_CHECK;
        ST_CHECK: begin
          if (slot_owned) begin
            miss_stb  <= 1'b1;
            miss_code <= MISS_CODE;
            miss_parm <= cur_dir;
            rx_drop   <= cur_dir;
            tx_irq    <= ~cur_dir;
            rx_irq    <= cur_dir;
            state     <= ST_IDLE;
          end else begin
            state <= ST_WR_LO;
          end
        end
        ST_WR_LO: state <= ST_WR_HI;
        ST_WR_HI: begin
          tx_irq <= ~cur_dir;
          rx_irq <= cur_dir;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(2) && mem_wdata[FLAG_B])); // R4
  AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !$past(mem_we)) |-> $past(mem_req && !mem_we, 2)); // R4
  AST_MISS_CODE: assert property (@(posedge clk) disable iff (rst)
    miss_stb |-> (miss_code == MISS_CODE && (miss_parm ? rx_irq : tx_irq))); // R6
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    miss_stb |-> !$past(mem_we)); // R6
  AST_DROP_RX_ONLY: assert property (@(posedge clk) disable iff (rst)
    rx_drop |-> (miss_stb && miss_parm && rx_irq)); // R7
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_irq, rx_irq})); // R9
endmodule

// File: rtl/intr_ring_writer.sv
module intr_ring_writer #(
  parameter int CTX_W  = 24,
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_evt_valid,
  output logic              tx_evt_ready,
  input  logic [CTX_W-1:0]  tx_evt_ctx,
  input  logic [IDX_W-1:0]  tx_evt_desc,
  input  logic              tx_evt_noint,
  input  logic              rx_evt_valid,
  output logic              rx_evt_ready,
  input  logic [CTX_W-1:0]  rx_evt_ctx,
  input  logic [IDX_W-1:0]  rx_evt_desc,
  input  logic              rx_evt_noint,
  input  logic [ADDR_W-1:0] tx_ring_base,
  input  logic [ADDR_W-1:0] rx_ring_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              miss_stb,
  output logic [2:0]        miss_code,
  output logic              miss_parm,
  output logic              rx_drop
);
  localparam int N_DIR = 2;

  logic             idle;
  logic             pick_rx;
  logic             acc_valid;
  logic [CTX_W-1:0] acc_ctx;
  logic [IDX_W-1:0] acc_desc;
  logic             acc_noint;
  logic [N_DIR-1:0] adv;
  logic [IDX_W-1:0] idx_q [N_DIR];

  irw_arbiter u_arb (
    .clk      (clk),
    .rst      (rst),
    .idle     (idle),
    .tx_valid (tx_evt_valid),
    .rx_valid (rx_evt_valid),
    .tx_ready (tx_evt_ready),
    .rx_ready (rx_evt_ready),
    .pick_rx  (pick_rx)
  );

  assign acc_valid = (tx_evt_valid & tx_evt_ready) | (rx_evt_valid & rx_evt_ready);
  assign acc_ctx   = pick_rx ? rx_evt_ctx   : tx_evt_ctx;
  assign acc_desc  = pick_rx ? rx_evt_desc  : tx_evt_desc;
  assign acc_noint = pick_rx ? rx_evt_noint : tx_evt_noint;

  for (genvar d = 0; d < N_DIR; d++) begin : g_ring
    irw_ring_index #(.IDX_W(IDX_W)) u_idx (
      .clk (clk),
      .rst (rst),
      .adv (adv[d]),
      .idx (idx_q[d])
    );
  end

  irw_sequencer #(
    .CTX_W  (CTX_W),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .idle      (idle),
    .acc_valid (acc_valid),
    .acc_dir   (pick_rx),
    .acc_ctx   (acc_ctx),
    .acc_desc  (acc_desc),
    .acc_noint (acc_noint),
    .tx_base   (tx_ring_base),
    .rx_base   (rx_ring_base),
    .tx_idx    (idx_q[0]),
    .rx_idx    (idx_q[1]),
    .adv       (adv),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .tx_irq    (tx_irq),
    .rx_irq    (rx_irq),
    .miss_stb  (miss_stb),
    .miss_code (miss_code),
    .miss_parm (miss_parm),
    .rx_drop   (rx_drop)
  );

  AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (idle && !$past(acc_valid && !acc_noint)) |-> !mem_req); // R8
endmodule

// File: tb/intr_ring_writer_bench.sv
`timescale 1ns/1ps
module intr_ring_writer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_evt_valid = 0, rx_evt_valid = 0;
  logic        tx_evt_ready, rx_evt_ready;
  logic [23:0] tx_evt_ctx = 0, rx_evt_ctx = 0;
  logic [6:0]  tx_evt_desc = 0, rx_evt_desc = 0;
  logic        tx_evt_noint = 0, rx_evt_noint = 0;
  logic [23:0] tx_ring_base = 24'h000100, rx_ring_base = 24'h000400;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        tx_irq, rx_irq, miss_stb, miss_parm, rx_drop;
  logic [2:0]  miss_code;

  int total = 0, bad = 0;
  int n_tx = 0, n_rx = 0, n_miss = 0, n_drop = 0, n_wr = 0, n_rd = 0;
  logic last_parm = 0;
  logic [2:0] last_code = 0;
  logic [23:0] wlog [0:1023];
  logic [15:0] mem [0:2047];
  int tx_i = 0, rx_i = 0;

  always #2.5 clk = ~clk;

  intr_ring_writer u_intr_ring_writer (.*);

  always_ff @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[11:1]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:1]];
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (tx_irq) n_tx++;
      if (rx_irq) n_rx++;
      if (rx_drop) n_drop++;
      if (miss_stb) begin n_miss++; last_parm = miss_parm; last_code = miss_code; end
      if (mem_req && !mem_we) n_rd++;
      if (mem_req && mem_we) begin wlog[n_wr % 1024] = mem_addr; n_wr++; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] slot_of(input logic [23:0] base, input int i);
    return base + 24'(4 * i);
  endfunction

  task automatic send_evt(input bit dir, input logic [23:0] ctx, input logic [6:0] desc, input bit noint);
    @(negedge clk);
    if (dir) begin rx_evt_valid = 1; rx_evt_ctx = ctx; rx_evt_desc = desc; rx_evt_noint = noint; end
    else     begin tx_evt_valid = 1; tx_evt_ctx = ctx; tx_evt_desc = desc; tx_evt_noint = noint; end
    while (!(dir ? rx_evt_ready : tx_evt_ready)) @(negedge clk);
    @(negedge clk);
    if (dir) rx_evt_valid = 0; else tx_evt_valid = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 tx_irq", tx_irq, 0);
    chk("R10 miss_stb", miss_stb, 0);
    chk("R10 rx_drop", rx_drop, 0);
    chk("R10 mem_req", mem_req, 0);
    chk("R10 ready", tx_evt_ready & rx_evt_ready, 1);
  endtask

  task automatic t_tx_post;
    int w0 = n_wr, t0 = n_tx, r0 = n_rd;
    logic [23:0] s = slot_of(tx_ring_base, tx_i);
    send_evt(0, 24'hABCDEF, 7'd5, 0);
    chk("R1 word0", mem[s[11:1]], 16'hCDEF);
    chk("R1 word1", mem[s[11:1] + 1], 16'h85AB);
    chk("R2 slot0 addr", wlog[w0], s);
    chk("R4 order second", wlog[w0 + 1], s + 2);
    chk("R4 read first", n_rd - r0, 1);
    chk("R5 tx irq", n_tx - t0, 1);
    tx_i++;
  endtask

  task automatic t_tx_next;
    logic [23:0] s = slot_of(tx_ring_base, tx_i);
    int r0 = n_rx;
    send_evt(0, 24'h123456, 7'd127, 0);
    chk("R3 next slot word0", mem[s[11:1]], 16'h3456);
    chk("R3 next slot word1", mem[s[11:1] + 1], 16'hFF12);
    chk("R9 no rx irq", n_rx - r0, 0);
    tx_i++;
  endtask

  task automatic t_rx_post;
    logic [23:0] s = slot_of(rx_ring_base, rx_i);
    int r0 = n_rx, m0 = n_miss;
    send_evt(1, 24'h00FF01, 7'd0, 0);
    chk("R1 rx word0", mem[s[11:1]], 16'hFF01);
    chk("R1 rx word1", mem[s[11:1] + 1], 16'h8000);
    chk("R5 rx irq", n_rx - r0, 1);
    chk("R6 no miss", n_miss - m0, 0);
    rx_i++;
  endtask

  task automatic t_tx_miss;
    logic [23:0] s = slot_of(tx_ring_base, tx_i);
    int w0 = n_wr, t0 = n_tx, m0 = n_miss, d0 = n_drop;
    mem[s[11:1]] = 16'h1234;
    mem[s[11:1] + 1] = 16'h8000;
    send_evt(0, 24'h777777, 7'd9, 0);
    chk("R6 tx miss count", n_miss - m0, 1);
    chk("R6 tx miss code", last_code, 7);
    chk("R6 tx miss parm", last_parm, 0);
    chk("R6 tx irq on miss", n_tx - t0, 1);
    chk("R6 no write on miss", n_wr - w0, 0);
    chk("R6 word0 kept", mem[s[11:1]], 16'h1234);
    chk("R7 no drop on tx", n_drop - d0, 0);
    mem[s[11:1] + 1] = 16'h0000;
    send_evt(0, 24'h777777, 7'd9, 0);
    chk("R6 retry same slot", mem[s[11:1]], 16'h7777);
    chk("R6 retry word1", mem[s[11:1] + 1], 16'h8977);
    tx_i++;
  endtask

  task automatic t_rx_miss;
    logic [23:0] s = slot_of(rx_ring_base, rx_i);
    int m0 = n_miss, d0 = n_drop, r0 = n_rx;
    mem[s[11:1] + 1] = 16'hFFFF;
    send_evt(1, 24'h010203, 7'd3, 0);
    chk("R6 rx miss parm", last_parm, 1);
    chk("R6 rx miss count", n_miss - m0, 1);
    chk("R7 rx drop", n_drop - d0, 1);
    chk("R6 rx irq on miss", n_rx - r0, 1);
    mem[s[11:1] + 1] = 16'h0000;
    send_evt(1, 24'h010203, 7'd3, 0);
    chk("R6 rx retry", mem[s[11:1] + 1], 16'h8301);
    rx_i++;
  endtask

  task automatic t_suppress;
    int w0 = n_wr, r0 = n_rd, t0 = n_tx, x0 = n_rx;
    logic [23:0] s = slot_of(tx_ring_base, tx_i);
    send_evt(0, 24'hDEAD00, 7'd1, 1);
    send_evt(1, 24'hDEAD01, 7'd2, 1);
    chk("R8 no mem access", (n_wr - w0) + (n_rd - r0), 0);
    chk("R8 no irq", (n_tx - t0) + (n_rx - x0), 0);
    send_evt(0, 24'h00BEEF, 7'd4, 0);
    chk("R8 index unchanged", wlog[w0], s);
    tx_i++;
  endtask

  task automatic t_wrap;
    logic [23:0] s;
    while (rx_i < 127) begin
      send_evt(1, 24'h000000 + 24'(rx_i), 7'(rx_i), 0);
      rx_i++;
    end
    s = slot_of(rx_ring_base, 127);
    send_evt(1, 24'h5A0042, 7'd127, 0);
    chk("R3 last slot", mem[s[11:1] + 1], 16'hFF5A);
    mem[rx_ring_base[11:1] + 1] = 16'h0000;
    send_evt(1, 24'hC30099, 7'd6, 0);
    chk("R3 wrap to slot0 word0", mem[rx_ring_base[11:1]], 16'h0099);
    chk("R3 wrap to slot0 word1", mem[rx_ring_base[11:1] + 1], 16'h86C3);
    rx_i = 1;
  endtask

  task automatic t_priority;
    int w0 = n_wr, t0 = n_tx, r0 = n_rx;
    logic [23:0] st = slot_of(tx_ring_base, tx_i);
    logic [23:0] sr = slot_of(rx_ring_base, rx_i);
    mem[sr[11:1] + 1] = 16'h0000;
    @(negedge clk);
    tx_evt_valid = 1; tx_evt_ctx = 24'h111111; tx_evt_desc = 7'd10; tx_evt_noint = 0;
    rx_evt_valid = 1; rx_evt_ctx = 24'h222222; rx_evt_desc = 7'd20; rx_evt_noint = 0;
    #0.5;
    chk("R9 rx ready first", rx_evt_ready, 1);
    chk("R9 tx held", tx_evt_ready, 0);
    @(negedge clk);
    rx_evt_valid = 0;
    while (!tx_evt_ready) @(negedge clk);
    @(negedge clk);
    tx_evt_valid = 0;
    repeat (8) @(negedge clk);
    chk("R9 rx written first", wlog[w0], sr);
    chk("R9 tx written later", wlog[w0 + 2], st);
    chk("R9 both irqs", (n_tx - t0) + (n_rx - r0), 2);
    tx_i++; rx_i++;
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_tx_post();
    t_tx_next();
    t_rx_post();
    t_tx_miss();
    t_rx_miss();
    t_suppress();
    t_wrap();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule